// File: doc/BRIEF.md
# Warning-Rate Supply Voltage Servo

This block closes a supply-voltage loop with no voltage reference and no analog comparator. Monitored logic raises a one-cycle warning whenever its timing slack runs short. The block counts those warnings over a fixed window of clock cycles and compares the count with a programmed target. If the count is above a tolerance band around the target, it asks for a higher supply. If the count is below that band, it asks for a lower supply. The loop therefore settles where the warning rate stays constant. With a window of 2^16 cycles and a rate of 2×10^-4 per cycle, the target is about 13 warnings per window.

Each decision appears as a one-cycle raise or lower pulse, together with a decision strobe. The same pulse steps a switch-count code that drives a digital regulator's power-switch array. A higher code means more switches are on, and so a higher supply. The code is held between programmable floor and ceiling values, and it starts at the ceiling, which is the safest setting.

Top module: `warn_rate_servo`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the code equals the ceiling input, and the raise, lower and strobe outputs are low.
- R2: The decision strobe is high for exactly one cycle in every WIN_LEN cycles. It first rises WIN_LEN cycles after reset is released, and it is low in every other cycle.
- R3: When a window's warning count is greater than target plus band, raise is high in that window's strobe cycle and lower is low.
- R4: When a window's warning count plus band is less than the target, lower is high in that window's strobe cycle and raise is low.
- R5: When the count lies within target−band to target+band inclusive, both raise and lower stay low in the strobe cycle.
- R6: A warning in any cycle of a window counts toward that window, including the window's last cycle. No count carries over into the next window.
- R7: The per-window count saturates at 2^WARN_W−1, so extra warnings beyond that value do not change the decision.
- R8: One cycle after a raise pulse, the code is one higher. One cycle after a lower pulse, the code is one lower.
- R9: A raise request when the code is at or above the ceiling leaves the code unchanged. A lower request when the code is at or below the floor also leaves it unchanged.
- R10: Raise and lower are never high together, and neither is high outside a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warn_i | input | 1 | Timing-warning pulse from the monitored logic; one warning per high cycle |
| target_i | input | WARN_W | Target warning count per window |
| band_i | input | WARN_W | Half-width of the tolerance band |
| code_min_i | input | CODE_W | Floor of the switch code |
| code_max_i | input | CODE_W | Ceiling of the switch code, loaded at reset |
| step_up_o | output | 1 | One-cycle request for a higher supply |
| step_dn_o | output | 1 | One-cycle request for a lower supply |
| win_done_o | output | 1 | Decision strobe, high for one cycle per window |
| code_o | output | CODE_W | Switch-count code for the regulator |

## Verification
A window is the WIN_LEN cycles that start at reset release or at a strobe cycle. Its decision appears on the strobe, raise and lower outputs in the first cycle after the window's last cycle. The code reflects that decision one cycle later. The bench drives warnings for exactly one window per call and samples on the falling clock edge. It checks the pulses in the strobe cycle, where the code still holds the previous window's result. It checks every other cycle of the window for stray pulses. The expected code comes from a model that applies the count, band and limits, so each change in the code is checked one window after it happens.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_RAISE = 2'd1,
        DIR_LOWER = 2'd2
    } step_dir_e;

    typedef struct packed {
        logic      strobe;
        step_dir_e dir;
    } decision_t;

    function automatic logic [1:0] dir_to_pulses(input step_dir_e d);
        return {d == DIR_RAISE, d == DIR_LOWER};
    endfunction

endpackage

// File: rtl/vsc_window_timer.sv
module vsc_window_timer #(
    parameter int WIN_LEN = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic last_o
);
    localparam int CW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign last_o = (cnt == LAST);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        last_o |=> cnt == '0);
    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (!last_o && !$past(rst)) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/vsc_warn_tally.sv
module vsc_warn_tally #(
    parameter int WARN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warn_i,
    input  logic              last_i,
    output logic [WARN_W-1:0] total_o
);
    localparam logic [WARN_W-1:0] TOP = '1;

    logic [WARN_W-1:0] tally;

    assign total_o = (tally == TOP) ? TOP : tally + WARN_W'(warn_i);

    always_ff @(posedge clk) begin
        if (rst || last_i) tally <= '0;
        else               tally <= total_o;
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        last_i |=> tally == '0);
    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (tally == TOP && !last_i) |=> tally == TOP);
endmodule

// File: rtl/vsc_rate_judge.sv
module vsc_rate_judge
    import vsc_pkg::*;
#(
    parameter int WARN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              last_i,
    input  logic [WARN_W-1:0] total_i,
    input  logic [WARN_W-1:0] target_i,
    input  logic [WARN_W-1:0] band_i,
    output decision_t         dec_o
);
    localparam int XW = WARN_W + 1;

    logic [XW-1:0] total_x, target_x, band_x;
    logic          too_many, too_few;
    step_dir_e     verdict;

    assign total_x  = {1'b0, total_i};
    assign target_x = {1'b0, target_i};
    assign band_x   = {1'b0, band_i};
    assign too_many = total_x > (target_x + band_x);
    assign too_few  = (total_x + band_x) < target_x;

    always_comb begin
        if (too_many)     verdict = DIR_RAISE;
        else if (too_few) verdict = DIR_LOWER;
        else              verdict = DIR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_o <= '{strobe: 1'b0, dir: DIR_HOLD};
        end else if (last_i) begin
            dec_o <= '{strobe: 1'b1, dir: verdict};
        end else begin
            dec_o <= '{strobe: 1'b0, dir: DIR_HOLD};
        end
    end

    assert_dir_legal_R10: assert property (@(posedge clk) disable iff (rst)
        dec_o.dir != 2'd3);
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !dec_o.strobe |-> dec_o.dir == DIR_HOLD);
endmodule

// File: rtl/vsc_code_reg.sv
module vsc_code_reg #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic [CODE_W-1:0] code_min_i,
    input  logic [CODE_W-1:0] code_max_i,
    output logic [CODE_W-1:0] code_o
);
    always_ff @(posedge clk) begin
        if (rst)                             code_o <= code_max_i;
        else if (up_i && code_o < code_max_i) code_o <= code_o + 1'b1;
        else if (dn_i && code_o > code_min_i) code_o <= code_o - 1'b1;
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> code_o == $past(code_max_i));
    assert_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (up_i && code_o < code_max_i) |=> code_o == $past(code_o) + 1'b1);
    assert_lower_R8: assert property (@(posedge clk) disable iff (rst)
        (dn_i && code_o > code_min_i) |=> code_o == $past(code_o) - 1'b1);
    assert_ceiling_R9: assert property (@(posedge clk) disable iff (rst)
        (up_i && code_o >= code_max_i) |=> code_o == $past(code_o));
    assert_floor_R9: assert property (@(posedge clk) disable iff (rst)
        (dn_i && code_o <= code_min_i) |=> code_o == $past(code_o));
    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!up_i && !dn_i) |=> code_o == $past(code_o));
endmodule

// File: rtl/warn_rate_servo.sv
module warn_rate_servo
    import vsc_pkg::*;
#(
    parameter int WIN_LEN = 1024,
    parameter int WARN_W  = 8,
    parameter int CODE_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warn_i,
    input  logic [WARN_W-1:0] target_i,
    input  logic [WARN_W-1:0] band_i,
    input  logic [CODE_W-1:0] code_min_i,
    input  logic [CODE_W-1:0] code_max_i,
    output logic              step_up_o,
    output logic              step_dn_o,
    output logic              win_done_o,
    output logic [CODE_W-1:0] code_o
);
    logic              last;
    logic [WARN_W-1:0] total;
    decision_t         dec;
    logic [1:0]        pulses;

    vsc_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk(clk), .rst(rst), .last_o(last)
    );

    vsc_warn_tally #(.WARN_W(WARN_W)) u_tally (
        .clk(clk), .rst(rst), .warn_i(warn_i), .last_i(last), .total_o(total)
    );

    vsc_rate_judge #(.WARN_W(WARN_W)) u_judge (
        .clk(clk), .rst(rst), .last_i(last), .total_i(total),
        .target_i(target_i), .band_i(band_i), .dec_o(dec)
    );

    assign pulses     = dir_to_pulses(dec.dir);
    assign step_up_o  = pulses[1];
    assign step_dn_o  = pulses[0];
    assign win_done_o = dec.strobe;

    vsc_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk(clk), .rst(rst), .up_i(step_up_o), .dn_i(step_dn_o),
        .code_min_i(code_min_i), .code_max_i(code_max_i), .code_o(code_o)
    );

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(step_up_o && step_dn_o));
    assert_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (step_up_o || step_dn_o) |-> win_done_o);
    assert_strobe_from_last_R2: assert property (@(posedge clk) disable iff (rst)
        last |=> win_done_o);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        win_done_o |=> !win_done_o);
endmodule

// File: tb/test_warn_rate_servo.sv
module test_warn_rate_servo;
    localparam int WIN = 64;
    localparam int WW  = 5;
    localparam int CW  = 4;
    localparam int SAT = (1 << WW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          warn = 1'b0;
    logic [WW-1:0] target = 5'd10;
    logic [WW-1:0] band = 5'd2;
    logic [CW-1:0] cmin = 4'd3;
    logic [CW-1:0] cmax = 4'd12;
    logic          up, dn, done;
    logic [CW-1:0] code;

    int errors = 0;
    int checks = 0;
    int code_m = 12;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    warn_rate_servo #(.WIN_LEN(WIN), .WARN_W(WW), .CODE_W(CW)) i_warn_rate_servo (
        .clk(clk), .rst(rst), .warn_i(warn), .target_i(target), .band_i(band),
        .code_min_i(cmin), .code_max_i(cmax), .step_up_o(up), .step_dn_o(dn),
        .win_done_o(done), .code_o(code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: warnings in the first n cycles; mode 1: in the last n cycles
    task automatic do_window(input int n, input int mode, input string req);
        int cnt, eu, ed, stray;
        stray = 0;
        for (int i = 0; i < WIN; i++) begin
            warn = (mode == 0) ? (i < n) : (i >= WIN - n);
            @(negedge clk);
            if (i < WIN - 1 && (done || up || dn)) stray++;
        end
        warn = 1'b0;
        cnt = (n > SAT) ? SAT : n;
        eu  = (cnt > int'(target) + int'(band)) ? 1 : 0;
        ed  = (cnt + int'(band) < int'(target)) ? 1 : 0;
        check({req, " R2 R10 no stray strobe"}, stray, 0);
        check({req, " R2 strobe"}, done, 1);
        check({req, " R3 raise"}, up, eu);
        check({req, " R4 lower"}, dn, ed);
        check({req, " R8 code before step"}, code, code_m);
        if (eu == 1 && code_m < int'(cmax)) code_m++;
        else if (ed == 1 && code_m > int'(cmin)) code_m--;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 code at ceiling in reset", code, 12);
        check("R1 pulses low in reset", up | dn | done, 0);
        rst = 1'b0;
        check("R1 code after release", code, 12);
    endtask

    task automatic t_deadband();
        do_window(8, 0, "R5 lower edge");
        do_window(10, 1, "R5 centre");
        do_window(12, 0, "R5 upper edge");
    endtask

    task automatic t_ceiling();
        do_window(13, 0, "R9 raise at ceiling");
    endtask

    task automatic t_lower_tail();
        do_window(7, 1, "R6 tail warnings lower");
        do_window(0, 0, "R4 zero warnings");
        do_window(20, 0, "R3 many warnings");
    endtask

    task automatic t_saturate();
        target = 5'd31;
        band   = 5'd0;
        do_window(64, 0, "R7 saturated count holds");
        do_window(30, 1, "R7 below saturation lowers");
        target = 5'd10;
        band   = 5'd2;
    endtask

    task automatic t_floor();
        for (int k = 0; k < 11; k++) do_window(0, 0, "R9 drive to floor");
        @(negedge clk);
        check("R9 code held at floor", code, code_m);
        check("R9 floor value", code, 3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_deadband();
        t_ceiling();
        t_lower_tail();
        t_saturate();
        t_floor();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule